// File: doc/BRIEF.md
# Branch condition and microstep sequencer

This block sits in the control path of a small single-bus processor. It keeps the four result flags produced by the ALU (zero, carry, sign and parity), each written only when its own update enable is high. From these flags it picks one branch condition through a 3-bit select field and presents that condition as a single bit. A condition enable gates the choice: with the enable low the presented bit is always 0.

The same block counts microinstruction steps. A step advance moves the counter forward. A microstep can also request a sequence restart. The counter then returns to the fetch step only when the selected condition is false. When the condition is true the sequence runs on to the next microstep. This is how conditional jumps, calls and returns carry out their remaining steps only when the branch is taken. The microstep number and a fetch indicator are outputs that address the microcode store, which lies outside this block.

Top module: `cond_step_seq`

## Requirements
- R1: While reset is asserted and after it is released, the step counter is 0, at_fetch is 1 and all four stored flags read as 0.
- R2: Flag bit positions in flag_in and flag_we are 0 = zero, 1 = carry, 2 = sign, 3 = parity. A stored flag takes its flag_in bit at a clock edge only when its own flag_we bit is 1. Otherwise it keeps its value.
- R3: With cond_en = 1, cond_sel 0 gives the zero flag, 1 gives its complement, 2 gives the carry flag and 3 gives its complement.
- R4: With cond_en = 1, cond_sel 4 (plus) gives the complement of the sign flag and cond_sel 5 (minus) gives the sign flag.
- R5: The parity flag is 1 for even parity. With cond_en = 1, cond_sel 7 (parity even) gives the parity flag and cond_sel 6 (parity odd) gives its complement.
- R6: With cond_en = 0, sel_flag is 0 for every cond_sel and every flag value.
- R7: With seq_restart = 0 and step_adv = 1, step_num increases by 1 at the next edge and wraps from 15 to 0. at_fetch is 1 exactly when step_num is 0.
- R8: With seq_restart = 1 and sel_flag = 0, step_num is 0 after the next edge, whatever step_adv is.
- R9: With seq_restart = 1 and sel_flag = 1, step_num increases by 1 at the next edge.
- R10: With seq_restart = 0 and step_adv = 0, step_num holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flag_in | input | 4 | New flag values from the ALU (0 zero, 1 carry, 2 sign, 3 parity) |
| flag_we | input | 4 | Per-flag update enables, same bit order |
| cond_sel | input | 3 | Branch condition select |
| cond_en | input | 1 | Condition enable; 0 forces sel_flag to 0 |
| seq_restart | input | 1 | Microstep asks to return to fetch if condition false |
| step_adv | input | 1 | Advance to next microstep |
| sel_flag | output | 1 | Selected condition value |
| step_num | output | 4 | Current microstep number |
| at_fetch | output | 1 | High when step_num is the fetch step 0 |

## Verification
All eight selects are run over flag words 0x0, 0x5, 0xA, 0xF and 0x3. Complementary flag pairs separate a select that is swapped with its neighbour, and mixed words separate a select that reads the wrong flag bit. Partial write enables show whether a flag picks up a value it was not told to take. For the counter, a restart is tried with a true condition, with a false condition, and with a true condition under a low enable, each with the advance input high. Plain advance runs cross the 15-to-0 wrap, and idle cycles alongside flag writes check that the count holds.

// File: rtl/cond_seq_pkg.sv
package cond_seq_pkg;

    localparam int NUM_FLAGS = 4;

    // flag bit positions in the stored flag word
    localparam int FLG_ZERO   = 0;
    localparam int FLG_CARRY  = 1;
    localparam int FLG_SIGN   = 2;
    localparam int FLG_PARITY = 3;

    typedef enum logic [2:0] {
        COND_ZERO   = 3'd0,
        COND_NZERO  = 3'd1,
        COND_CARRY  = 3'd2,
        COND_NCARRY = 3'd3,
        COND_PLUS   = 3'd4,
        COND_MINUS  = 3'd5,
        COND_PODD   = 3'd6,
        COND_PEVEN  = 3'd7
    } cond_e;

endpackage

// File: rtl/flag_store.sv
module flag_store
    import cond_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] flag_in,
    input  logic [NUM_FLAGS-1:0] flag_we,
    output logic [NUM_FLAGS-1:0] flags
);

    typedef struct packed {
        logic [NUM_FLAGS-1:0] val;
    } fstate_t;

    fstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_FLAGS; i++) begin
            if (flag_we[i]) begin
                st_d.val[i] = flag_in[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.val;

endmodule

// File: rtl/cond_select.sv
module cond_select
    import cond_seq_pkg::*;
(
    input  logic [NUM_FLAGS-1:0] flags,
    input  logic [2:0]           cond_sel,
    input  logic                 cond_en,
    output logic                 sel_flag
);

    logic raw;

    always_comb begin
        unique case (cond_e'(cond_sel))
            COND_ZERO:   raw =  flags[FLG_ZERO];
            COND_NZERO:  raw = ~flags[FLG_ZERO];
            COND_CARRY:  raw =  flags[FLG_CARRY];
            COND_NCARRY: raw = ~flags[FLG_CARRY];
            COND_PLUS:   raw = ~flags[FLG_SIGN];
            COND_MINUS:  raw =  flags[FLG_SIGN];
            COND_PODD:   raw = ~flags[FLG_PARITY];
            COND_PEVEN:  raw =  flags[FLG_PARITY];
            default:     raw = 1'b0;
        endcase
    end

    assign sel_flag = cond_en & raw;

endmodule

// File: rtl/step_seq.sv
module step_seq #(
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_restart,
    input  logic              step_adv,
    input  logic              cond_true,
    output logic [STEP_W-1:0] step_num,
    output logic              at_fetch
);

    localparam logic [STEP_W-1:0] FETCH_STEP = '0;
    localparam logic [STEP_W-1:0] STEP_ONE   = STEP_W'(1);

    typedef struct packed {
        logic [STEP_W-1:0] step;
    } sstate_t;

    sstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (seq_restart && !cond_true) begin
            st_d.step = FETCH_STEP;
        end else if (seq_restart || step_adv) begin
            st_d.step = st_q.step + STEP_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{step: FETCH_STEP};
        end else begin
            st_q <= st_d;
        end
    end

    assign step_num = st_q.step;
    assign at_fetch = (st_q.step == FETCH_STEP);

endmodule

// File: rtl/cond_step_seq.sv
module cond_step_seq
    import cond_seq_pkg::*;
#(
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        flag_in,
    input  logic [3:0]        flag_we,
    input  logic [2:0]        cond_sel,
    input  logic              cond_en,
    input  logic              seq_restart,
    input  logic              step_adv,
    output logic              sel_flag,
    output logic [STEP_W-1:0] step_num,
    output logic              at_fetch
);

    logic [NUM_FLAGS-1:0] flags_q;

    flag_store i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .flag_in (flag_in),
        .flag_we (flag_we),
        .flags   (flags_q)
    );

    cond_select i_cond (
        .flags    (flags_q),
        .cond_sel (cond_sel),
        .cond_en  (cond_en),
        .sel_flag (sel_flag)
    );

    step_seq #(.STEP_W(STEP_W)) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .seq_restart (seq_restart),
        .step_adv    (step_adv),
        .cond_true   (sel_flag),
        .step_num    (step_num),
        .at_fetch    (at_fetch)
    );

endmodule

// File: rtl/cond_step_seq_chk.sv
module cond_step_seq_chk #(
    parameter int STEP_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cond_en,
    input logic              seq_restart,
    input logic              step_adv,
    input logic              sel_flag,
    input logic [STEP_W-1:0] step_num
);

    // R6: disabled condition never reads as true
    p_disabled_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cond_en |-> !sel_flag);

    // R8: restart with a false condition returns to fetch
    p_restart_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_restart && !sel_flag) |=> (step_num == '0));

    // R9: restart with a true condition moves on one step
    p_taken_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_restart && sel_flag) |=> (step_num == STEP_W'($past(step_num) + 1'b1)));

    // R7: plain advance moves on one step
    p_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_restart && step_adv) |=> (step_num == STEP_W'($past(step_num) + 1'b1)));

    // R10: idle cycle holds the step
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_restart && !step_adv) |=> $stable(step_num));

endmodule

bind cond_step_seq cond_step_seq_chk #(.STEP_W(STEP_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cond_en     (cond_en),
    .seq_restart (seq_restart),
    .step_adv    (step_adv),
    .sel_flag    (sel_flag),
    .step_num    (step_num)
);

// File: tb/test_cond_step_seq.sv
`timescale 1ns/1ps
module test_cond_step_seq;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] flag_in, flag_we;
    logic [2:0] cond_sel;
    logic       cond_en, seq_restart, step_adv;
    logic       sel_flag;
    logic [3:0] step_num;
    logic       at_fetch;

    always #5 clk = ~clk;

    cond_step_seq i_cond_step_seq (
        .clk(clk), .rst_n(rst_n), .flag_in(flag_in), .flag_we(flag_we),
        .cond_sel(cond_sel), .cond_en(cond_en), .seq_restart(seq_restart),
        .step_adv(step_adv), .sel_flag(sel_flag), .step_num(step_num),
        .at_fetch(at_fetch)
    );

    typedef struct {
        logic       sel;
        logic [3:0] step;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    logic [3:0] m_flags = '0;
    logic [3:0] m_step  = '0;

    // condition model: bit0 zero, bit1 carry, bit2 sign, bit3 parity (1 = even)
    function automatic logic model_sel(logic [3:0] f, logic [2:0] cs, logic ce);
        logic v;
        case (cs)
            3'd0: v =  f[0];
            3'd1: v = ~f[0];
            3'd2: v =  f[1];
            3'd3: v = ~f[1];
            3'd4: v = ~f[2];
            3'd5: v =  f[2];
            3'd6: v = ~f[3];
            default: v = f[3];
        endcase
        return ce & v;
    endfunction

    task automatic chk(logic [3:0] act, logic [3:0] exp, string tag, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(logic [3:0] fin, logic [3:0] fwe, logic [2:0] cs,
                         logic ce, logic rs, logic adv, string tag);
        exp_t e;
        @(negedge clk);
        flag_in = fin; flag_we = fwe; cond_sel = cs;
        cond_en = ce; seq_restart = rs; step_adv = adv;
        #1;
        e.sel = model_sel(m_flags, cs, ce);
        if (rs && !e.sel) m_step = 4'd0;
        else if (rs || adv) m_step = m_step + 4'd1;
        e.step = m_step;
        e.tag  = tag;
        q.push_back(e);
        m_flags = (m_flags & ~fwe) | (fin & fwe);
    endtask

    // monitor: condition checked in the drive cycle, step after the edge
    initial begin
        exp_t e;
        forever begin
            wait (q.size() > 0);
            e = q.pop_front();
            chk({3'b0, sel_flag}, {3'b0, e.sel}, e.tag, "sel_flag");
            @(posedge clk);
            #1;
            chk(step_num, e.step, e.tag, "step_num");
            chk({3'b0, at_fetch}, {3'b0, (e.step == 4'd0)}, e.tag, "at_fetch");
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    function automatic string sel_tag(int cs);
        if (cs < 4) return "R3";
        if (cs < 6) return "R4";
        return "R5";
    endfunction

    initial begin
        rst_n = 1'b0; flag_in = '0; flag_we = '0; cond_sel = '0;
        cond_en = 1'b0; seq_restart = 1'b0; step_adv = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(step_num, 4'd0, "R1", "step_num in reset");
        chk({3'b0, at_fetch}, 4'd1, "R1", "at_fetch in reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R1: flags start cleared
        drive(4'h0, 4'h0, 3'd1, 1, 0, 0, "R1");
        drive(4'h0, 4'h0, 3'd0, 1, 0, 0, "R1");
        drive(4'h0, 4'h0, 3'd7, 1, 0, 0, "R1");

        // R2: only enabled flags change
        drive(4'hF, 4'b0001, 3'd0, 1, 0, 0, "R2");
        drive(4'hF, 4'b0000, 3'd0, 1, 0, 0, "R2");
        drive(4'h0, 4'b0000, 3'd2, 1, 0, 0, "R2");
        drive(4'h0, 4'b0000, 3'd5, 1, 0, 0, "R2");
        drive(4'h0, 4'b0000, 3'd7, 1, 0, 0, "R2");
        drive(4'hF, 4'b1010, 3'd0, 1, 0, 0, "R2");
        drive(4'h0, 4'b0000, 3'd2, 1, 0, 0, "R2");
        drive(4'h0, 4'b0000, 3'd7, 1, 0, 0, "R2");
        drive(4'h0, 4'b0000, 3'd5, 1, 0, 0, "R2");

        // R3, R4, R5: every select over several flag words
        foreach (pats[k]) begin
            drive(pats[k], 4'hF, 3'd0, 1, 0, 0, "R2");
            for (int cs = 0; cs < 8; cs++) begin
                drive(4'h0, 4'h0, 3'(cs), 1, 0, 0, sel_tag(cs));
            end
        end

        // R6: disabled condition
        drive(4'hF, 4'hF, 3'd0, 0, 0, 0, "R6");
        for (int cs = 0; cs < 8; cs++) drive(4'h0, 4'h0, 3'(cs), 0, 0, 0, "R6");
        drive(4'h0, 4'hF, 3'd0, 0, 0, 0, "R6");
        for (int cs = 0; cs < 8; cs++) drive(4'h0, 4'h0, 3'(cs), 0, 0, 0, "R6");

        // R7: advance and wrap
        for (int i = 0; i < 20; i++) drive(4'h0, 4'h0, 3'd0, 1, 0, 1, "R7");

        // R10: hold with flags changing
        for (int i = 0; i < 3; i++) drive(4'(i * 5), 4'hF, 3'd0, 1, 0, 0, "R10");

        // R8: restart with false condition (zero flag currently 0 after 4'hA write)
        drive(4'h0, 4'hF, 3'd0, 1, 0, 1, "R7");
        drive(4'h0, 4'h0, 3'd0, 1, 1, 1, "R8");
        drive(4'h0, 4'h0, 3'd0, 1, 0, 1, "R7");
        drive(4'h0, 4'h0, 3'd0, 1, 0, 1, "R7");
        drive(4'h0, 4'h0, 3'd0, 1, 1, 0, "R8");

        // R9: restart with true condition continues
        drive(4'h0, 4'h0, 3'd1, 1, 1, 0, "R9");
        drive(4'h0, 4'h0, 3'd1, 1, 1, 1, "R9");
        drive(4'h0, 4'h0, 3'd3, 1, 1, 0, "R9");
        // R8 with a true flag but condition disabled
        drive(4'h0, 4'h0, 3'd1, 0, 1, 1, "R8");
        drive(4'h0, 4'h0, 3'd1, 1, 0, 0, "R10");

        wait (q.size() == 0);
        @(posedge clk);
        #3;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    logic [3:0] pats [5] = '{4'h0, 4'h5, 4'hA, 4'hF, 4'h3};

endmodule